// File: doc/BRIEF.md
# Seeded Byte-Position Scrambler

This block hides a block of bytes by moving each byte to a new position, without changing any data bit. A secret nonzero seed sets up a linear feedback shift register. During a block the register steps once per cycle, and its state goes straight onto the data-memory address lines. When scrambling, the byte at buffer index k is copied to the data-memory location named by the k-th register state. When unscrambling with the same seed, the byte at that location is read back and written to buffer index k. This restores the original order. Only the seed has to be shared. The address sequence never leaves the block except as memory addresses.

Both memories are external and read combinationally. They are shared by two cores. The core-select bit, captured when a block starts, becomes the top address bit on both sides, so each core works in its own half. A block is as long as one half: 2^ADDR_W bytes. It moves one byte per cycle with no gaps. The register is extended with the all-zero state, so every address in the half, including 0, is used exactly once.

Top module: `seeded_byte_scrambler`

## Requirements
- R1: After reset, done, seed_err, buf_we and mem_we are 0, and the stored seed is 1.
- R2: A seed_we pulse with a nonzero seed_in stores that value as the seed and clears seed_err on the next cycle.
- R3: A seed_we pulse with seed_in equal to zero sets seed_err and leaves the stored seed unchanged.
- R4: The first address of each block is the stored seed. Each later address s' comes from s by shifting left, with the new LSB = s[W-1] XOR s[TAP] XOR (s[W-2:0]==0). For W=4, TAP=2, and seed 1 gives 1,2,4,9,3,6,13,10,5,11,7,15,14,12,8,0.
- R5: With decrypt=0, mem_we is high for 2^ADDR_W consecutive cycles starting the cycle after start is accepted. The byte at buffer index k is written to data memory at the k-th address.
- R6: With decrypt=1, buf_we is high for 2^ADDR_W consecutive cycles. The byte read from the k-th address is written to buffer index k, so unscrambling with the same seed restores the block.
- R7: Within one block every logical address is written or read exactly once.
- R8: core_sel is captured when start is accepted and is the MSB of both buf_addr and mem_addr for the whole block. The other half is left untouched.
- R9: done is high for exactly one cycle, in the cycle after the last byte transfer, and no strobe is high in that cycle.
- R10: start during a block is ignored, and a seed written during a block takes effect only from the next block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| seed_we | input | 1 | Seed write strobe |
| seed_in | input | ADDR_W | Seed value |
| seed_err | output | 1 | Last seed write was rejected (zero) |
| start | input | 1 | Begin a block (accepted only when idle) |
| decrypt | input | 1 | 0 = scramble buffer to memory, 1 = unscramble memory to buffer |
| core_sel | input | 1 | Selects the half of both memories |
| buf_addr | output | ADDR_W+1 | Buffer address (core bit, byte index) |
| buf_we | output | 1 | Buffer write strobe |
| buf_wdata | output | DATA_W | Buffer write data |
| buf_rdata | input | DATA_W | Buffer combinational read data |
| mem_addr | output | ADDR_W+1 | Data memory address (core bit, shift register state) |
| mem_we | output | 1 | Data memory write strobe |
| mem_wdata | output | DATA_W | Data memory write data |
| mem_rdata | input | DATA_W | Data memory combinational read data |
| done | output | 1 | One-cycle end-of-block pulse |

## Verification
Some rules are checked by assertions on every cycle:
- done lasts a single cycle and arrives only after every address in the half has been visited.
- No address repeats within a block.
- The two write strobes are never both high.
- The core bit stays fixed during a block.
- Each seed write is either accepted or rejected as required.

Other behaviour only the bench scenarios can show:
- The exact address order for a known seed, including a seed loaded mid-sequence.
- A round trip that restores the original bytes.
- That the other core's half is untouched.
- That a mid-block start or seed write leaves the current layout alone but changes the next one.

// File: rtl/scr_pkg.sv
// Package: shared types and tap selection for the byte-position scrambler.
// Assumes shift register widths from 3 to 7 bits.
package scr_pkg;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_t;

    // Second feedback tap (beside the MSB) of a maximal-length register of width w.
    function automatic int lfsr_tap(input int w);
        case (w)
            3:       return 1;
            4:       return 2;
            5:       return 2;
            6:       return 4;
            7:       return 5;
            default: return 2;
        endcase
    endfunction

endpackage

// File: rtl/scr_seed_store.sv
// Seed holder: keeps the secret start state of the address generator.
// A zero seed is refused and flagged, so the stored seed is always nonzero.
module scr_seed_store #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         seed_we,
    input  logic [W-1:0] seed_in,
    output logic [W-1:0] seed_q,
    output logic         err_q
);

    localparam logic [W-1:0] RESET_SEED = W'(1);

    // Accept nonzero seeds, flag and drop zero ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seed_q <= RESET_SEED;
            err_q  <= 1'b0;
        end else if (seed_we) begin
            if (seed_in == '0) begin
                err_q <= 1'b1;
            end else begin
                seed_q <= seed_in;
                err_q  <= 1'b0;
            end
        end
    end

    a_r3_zero_seed_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (seed_we && seed_in == '0) |=> (err_q && $stable(seed_q)));

    a_r2_seed_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (seed_we && seed_in != '0) |=> (!err_q && seed_q == $past(seed_in)));

endmodule

// File: rtl/scr_addr_lfsr.sv
// Address generator: a maximal-length shift register extended with the
// all-zero state, so it walks all 2^W values once per period.
// Assumes load and step are never both wanted (load wins).
module scr_addr_lfsr #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] seed,
    output logic [W-1:0] state
);

    localparam int TAP = scr_pkg::lfsr_tap(W);

    logic fb;

    // Feedback with the zero-run term that splices the all-zero state in.
    always_comb begin
        fb = state[W-1] ^ state[TAP] ^ (state[W-2:0] == '0);
    end

    // Load the seed at block start, then advance once per transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= W'(1);
        end else if (load) begin
            state <= seed;
        end else if (step) begin
            state <= {state[W-2:0], fb};
        end
    end

    a_r4_step_moves: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> (state != $past(state)));

endmodule

// File: rtl/scr_sequencer.sv
// Block sequencer: accepts start when idle, captures mode and core bit,
// counts 2^W transfers and pulses done once after the last one.
module scr_sequencer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         decrypt,
    input  logic         core_sel,
    output logic         run,
    output logic         load,
    output logic [W-1:0] count,
    output logic         mode_q,
    output logic         core_q,
    output logic         done
);

    import scr_pkg::*;

    localparam logic [W-1:0] LAST = '1;

    seq_state_t st;

    // Decode run and accepted-start strobes from the state.
    always_comb begin
        run  = (st == SEQ_RUN);
        load = (st == SEQ_IDLE) && start;
    end

    // Step through the block and raise the end pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= SEQ_IDLE;
            count  <= '0;
            mode_q <= 1'b0;
            core_q <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                SEQ_IDLE: begin
                    if (start) begin
                        st     <= SEQ_RUN;
                        count  <= '0;
                        mode_q <= decrypt;
                        core_q <= core_sel;
                    end
                end
                SEQ_RUN: begin
                    count <= count + 1'b1;
                    if (count == LAST) begin
                        st   <= SEQ_IDLE;
                        done <= 1'b1;
                    end
                end
                default: st <= SEQ_IDLE;
            endcase
        end
    end

    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r8_core_held: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run)) |-> ($stable(core_q) && $stable(mode_q)));

    a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (run && start && count != LAST) |=> (run && count == $past(count) + 1'b1));

endmodule

// File: rtl/seeded_byte_scrambler.sv
// Top: moves a block of bytes between a shared buffer and a shared data
// memory, using shift register states as data-memory addresses.
// Assumes both memories return read data combinationally from the address.
module seeded_byte_scrambler #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seed_we,
    input  logic [ADDR_W-1:0] seed_in,
    output logic              seed_err,
    input  logic              start,
    input  logic              decrypt,
    input  logic              core_sel,
    output logic [ADDR_W:0]   buf_addr,
    output logic              buf_we,
    output logic [DATA_W-1:0] buf_wdata,
    input  logic [DATA_W-1:0] buf_rdata,
    output logic [ADDR_W:0]   mem_addr,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              done
);

    localparam int BLOCK = 1 << ADDR_W;

    logic [ADDR_W-1:0] seed_q;
    logic [ADDR_W-1:0] lfsr_q;
    logic [ADDR_W-1:0] count;
    logic              run;
    logic              load;
    logic              mode_q;
    logic              core_q;

    scr_seed_store #(.W(ADDR_W)) u_seed (
        .clk     (clk),
        .rst_n   (rst_n),
        .seed_we (seed_we),
        .seed_in (seed_in),
        .seed_q  (seed_q),
        .err_q   (seed_err)
    );

    scr_sequencer #(.W(ADDR_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .decrypt  (decrypt),
        .core_sel (core_sel),
        .run      (run),
        .load     (load),
        .count    (count),
        .mode_q   (mode_q),
        .core_q   (core_q),
        .done     (done)
    );

    scr_addr_lfsr #(.W(ADDR_W)) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .step  (run),
        .seed  (seed_q),
        .state (lfsr_q)
    );

    // Route addresses with the core bit on top and steer data by mode.
    always_comb begin
        buf_addr  = {core_q, count};
        mem_addr  = {core_q, lfsr_q};
        buf_we    = run && mode_q;
        mem_we    = run && !mode_q;
        buf_wdata = mem_rdata;
        mem_wdata = buf_rdata;
    end

    // Addresses visited in the current block (assertion support).
    logic [BLOCK-1:0] seen;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen <= '0;
        end else if (load) begin
            seen <= '0;
        end else if (run) begin
            seen[lfsr_q] <= 1'b1;
        end
    end

    a_r7_visit_once: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> !seen[lfsr_q]);

    a_r9_done_after_all: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (seen == '1 && !buf_we && !mem_we));

    a_r5_one_direction: assert property (@(posedge clk) disable iff (!rst_n)
        !(buf_we && mem_we));

endmodule

// File: tb/test_seeded_byte_scrambler.sv
module test_seeded_byte_scrambler;

    localparam int AW = 4;
    localparam int DW = 8;
    localparam int N  = 1 << AW;

    // Expected address order from seed 1 (R4).
    localparam logic [AW-1:0] SEQ [N] = '{4'd1, 4'd2, 4'd4, 4'd9, 4'd3, 4'd6, 4'd13, 4'd10,
                                          4'd5, 4'd11, 4'd7, 4'd15, 4'd14, 4'd12, 4'd8, 4'd0};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          seed_we = 1'b0;
    logic [AW-1:0] seed_in = '0;
    logic          seed_err;
    logic          start = 1'b0;
    logic          decrypt = 1'b0;
    logic          core_sel = 1'b0;
    logic [AW:0]   buf_addr;
    logic          buf_we;
    logic [DW-1:0] buf_wdata;
    logic [DW-1:0] buf_rdata;
    logic [AW:0]   mem_addr;
    logic          mem_we;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata;
    logic          done;

    logic [DW-1:0] bufm [2*N];
    logic [DW-1:0] datm [2*N];
    logic [DW-1:0] snap [N];

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    seeded_byte_scrambler #(.ADDR_W(AW), .DATA_W(DW)) i_seeded_byte_scrambler (
        .clk(clk), .rst_n(rst_n), .seed_we(seed_we), .seed_in(seed_in),
        .seed_err(seed_err), .start(start), .decrypt(decrypt), .core_sel(core_sel),
        .buf_addr(buf_addr), .buf_we(buf_we), .buf_wdata(buf_wdata), .buf_rdata(buf_rdata),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .done(done)
    );

    assign buf_rdata = bufm[buf_addr];
    assign mem_rdata = datm[mem_addr];

    always @(posedge clk) begin
        if (buf_we) bufm[buf_addr] <= buf_wdata;
        if (mem_we) datm[mem_addr] <= mem_wdata;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic load_seed(input logic [AW-1:0] v);
        @(negedge clk);
        seed_we = 1'b1;
        seed_in = v;
        @(negedge clk);
        seed_we = 1'b0;
    endtask

    // Run one block, checking strobes and done timing; optional mid-block poke.
    task automatic run_block(input logic dec, input logic core, input int mid);
        @(negedge clk);
        start = 1'b1;
        decrypt = dec;
        core_sel = core;
        @(negedge clk);
        start = 1'b0;
        chk(dec ? "R6 strobe" : "R5 strobe", dec ? buf_we : mem_we, 1);
        for (int i = 1; i <= N; i++) begin
            @(negedge clk);
            if (start) start = 1'b0;
            if (seed_we) seed_we = 1'b0;
            if (i < N) begin
                chk("R9 done early", done, 0);
                chk(dec ? "R6 strobe" : "R5 strobe", dec ? buf_we : mem_we, 1);
            end else begin
                chk("R9 done pulse", done, 1);
                chk("R9 strobes off", buf_we | mem_we, 0);
            end
            if (i == mid) begin
                start = 1'b1;
                seed_we = 1'b1;
                seed_in = 4'd5;
                decrypt = ~dec;
            end
        end
        @(negedge clk);
        chk("R9 done width", done, 0);
    endtask

    initial begin
        #400000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int a = 0; a < 2*N; a++) begin
            bufm[a] = '0;
            datm[a] = '0;
        end
        repeat (3) @(negedge clk);
        chk("R1 done", done, 0);
        chk("R1 seed_err", seed_err, 0);
        chk("R1 buf_we", buf_we, 0);
        chk("R1 mem_we", mem_we, 0);
        rst_n = 1'b1;

        // R1 reset seed is 1; R4/R5 scramble walks the table.
        for (int k = 0; k < N; k++) bufm[k] = DW'(8'hA0 + k);
        run_block(1'b0, 1'b0, -1);
        for (int k = 0; k < N; k++)
            chk("R4 R5 encrypt layout", datm[SEQ[k]], 8'hA0 + k);

        // R6 round trip restores the buffer.
        for (int k = 0; k < N; k++) bufm[k] = '0;
        run_block(1'b1, 1'b0, -1);
        for (int k = 0; k < N; k++)
            chk("R6 decrypt restore", bufm[k], 8'hA0 + k);

        // R2 seed 9, R4 starts mid table, R7 every address once.
        load_seed(4'd9);
        chk("R2 err clear", seed_err, 0);
        for (int k = 0; k < N; k++) begin
            bufm[k] = DW'(k);
            datm[k] = 8'hFF;
        end
        run_block(1'b0, 1'b0, -1);
        for (int k = 0; k < N; k++)
            chk("R4 seed 9 layout", datm[SEQ[(k + 3) % N]], k);
        begin
            logic [N-1:0] hit = '0;
            for (int a = 0; a < N; a++)
                if (datm[a] < N) hit[datm[a][AW-1:0]] = 1'b1;
            chk("R7 all addresses once", int'(hit), (1 << N) - 1);
        end

        // R3 zero seed refused, seed 9 still in use.
        load_seed(4'd0);
        chk("R3 err set", seed_err, 1);
        for (int k = 0; k < N; k++) bufm[k] = DW'(8'h50 + k);
        run_block(1'b0, 1'b0, -1);
        for (int k = 0; k < N; k++)
            chk("R3 seed kept", datm[SEQ[(k + 3) % N]], 8'h50 + k);

        // R2 a good seed clears the flag.
        load_seed(4'd1);
        chk("R2 err cleared", seed_err, 0);

        // R8 core 1 uses the upper halves only.
        for (int k = 0; k < N; k++) begin
            bufm[N + k] = DW'(8'hC0 + k);
            snap[k] = datm[k];
        end
        run_block(1'b0, 1'b1, -1);
        for (int k = 0; k < N; k++) begin
            chk("R8 upper layout", datm[N + SEQ[k]], 8'hC0 + k);
            chk("R8 lower untouched", datm[k], snap[k]);
        end

        // R10 start and seed write mid-block do not disturb the block.
        for (int k = 0; k < N; k++) bufm[k] = DW'(8'h30 + k);
        run_block(1'b0, 1'b0, 4);
        for (int k = 0; k < N; k++)
            chk("R10 layout unchanged", datm[SEQ[k]], 8'h30 + k);
        run_block(1'b0, 1'b0, -1);
        for (int k = 0; k < N; k++)
            chk("R10 new seed next block", datm[SEQ[(k + 8) % N]], 8'h30 + k);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule